// File: doc/BRIEF.md
# Debug Processor Control Port

This block is one of the targets a scan-chain debug selector routes data scans to. Every scan it receives is a sequence of serial bits framed by a capture cycle and an update cycle. It decodes short command words into three actions. It keeps a two-bit control register that holds the processor in a stall or in reset. It reads that register back through a read-by-NOP convention. It also moves bursts of 32-bit words between the scan path and the processor's debug register space over a simple request/acknowledge bus.

A command word is shifted least significant bit first. The decoder looks only at the bits that arrived last in the scan. The final bit is a routing flag, which must be 0 for this block to act. The four bits before the flag form the opcode, with opcode bit 3 arriving just before the flag. A register command places a one-bit register index before the opcode and two data bits before the index. A burst command sends a 16-bit word count first, then a 32-bit start address, then the opcode and the flag.

Burst traffic is handled by a state machine with these states:
- `B_IDLE`: the block decodes commands.
- `B_WR_START` → `B_WR_DATA` → `B_WR_CRC` → `B_WR_MATCH`: a write burst. The block waits for a start bit, takes the words, takes a checksum, and then shows the comparison result.
- `B_RD_STATUS` → `B_RD_DATA` → `B_RD_CRC` → `B_RD_TAIL`: a read burst. The block reports readiness, shifts out the words, shifts out a checksum, and then drives zeros.

The transitions are as follows:
- A command update enters a write or read chain from `B_IDLE`.
- The last bit of each word or checksum advances the chain.
- An update in any burst state returns the machine to `B_IDLE`.

Top module: `dbgcpu_port`

## Requirements
- R1: A command acts only if its last shifted bit (flag) is 0; the 4 preceding bits are the opcode (bit 3 arrives last). A register write with flag 1 changes nothing.
- R2: After reset the control register is 0, cpu_stall_o, cpu_reset_o, cpu_req_o and scan_tdo_o are 0, and register index 0 is selected.
- R3: Opcode 0x9 with index 0 loads the two data bits into the control register at the update cycle: bit 0 drives cpu_stall_o, bit 1 drives cpu_reset_o.
- R4: After opcode 0x0 (NOP), the next scan shifts out the selected register least significant bit first from its first shift cycle. A scan that does not follow a NOP shifts out zeros.
- R5: Opcode 0xD loads the index bit into the selection, which is held across later scans. Index 1 reads as zeros, and a write that names index 1 is ignored.
- R6: A cycle with cpu_bkpt_i high sets control bit 0, so the processor stalls and the bit reads back as 1 until a write clears it.
- R7: Opcode 0x3 starts a write burst. In the next scan, zeros are skipped until a 1 start bit; then count×32 data bits follow, LSB first, and word k is written to start address + 4k.
- R8: After the data of a write burst, 32 checksum bits are taken. The checksum is reflected polynomial 0xEDB88320, initial value all ones, no final inversion, over the data bits in shift order. On the next shift, tdo shows 1 on a match and 0 otherwise.
- R9: Opcode 0x7 starts a read burst. In the next scan, tdo is 0 until the first word has been fetched, then a single 1, then the words from ascending addresses, LSB first.
- R10: After the read data, the checksum of the shifted data bits (same rule as R8) follows LSB first, and zeros follow after that.
- R11: An update during a burst ends it, and data bits of a burst are never decoded as a command; register commands work again right after.
- R12: Scans with the port not selected, and opcodes other than 0x0, 0x3, 0x7, 0x9 and 0xD, change nothing.
- R13: A processor bus request keeps its address, direction and data stable until acknowledged, and at most one request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_sel_i | input | 1 | This port is the routed scan target |
| scan_capture_i | input | 1 | Capture cycle at scan start |
| scan_shift_i | input | 1 | One bit moves in and out this cycle |
| scan_update_i | input | 1 | Update cycle at scan end |
| scan_tdi_i | input | 1 | Serial data in |
| scan_tdo_o | output | 1 | Serial data out, valid during the shift cycle |
| cpu_bkpt_i | input | 1 | Processor hit a breakpoint |
| cpu_stall_o | output | 1 | Stall request to the processor |
| cpu_reset_o | output | 1 | Reset to the processor |
| cpu_req_o | output | 1 | Debug bus request |
| cpu_we_o | output | 1 | Request is a write |
| cpu_addr_o | output | 32 | Debug register address |
| cpu_wdata_o | output | 32 | Write data |
| cpu_rdata_i | input | 32 | Read data, valid with acknowledge |
| cpu_ack_i | input | 1 | Request accepted |

## Verification
Control register writes show up on cpu_stall_o and cpu_reset_o at the clock edge that closes the update cycle. The bench therefore reads them in the low phase that follows the scan. A NOP takes effect at the capture edge of the next scan, so the bench reads tdo in the low phase of each shift cycle, before the edge that moves the bit. For a read burst, the ready bit appears only after the fetch round trip. The bench accepts it anywhere in the first eight shifts and checks everything after it at fixed bit offsets. The match bit of a write burst is due on the shift after the last checksum bit, and processor writes are checked by a monitor at the moment they are acknowledged.

// File: rtl/dbgcpu_pkg.sv
package dbgcpu_pkg;

    localparam int OP_W   = 4;
    localparam int IDX_W  = 1;
    localparam int CTRL_W = 2;

    localparam logic [OP_W-1:0] OP_NOP    = 4'h0;
    localparam logic [OP_W-1:0] OP_BWR32  = 4'h3;
    localparam logic [OP_W-1:0] OP_BRD32  = 4'h7;
    localparam logic [OP_W-1:0] OP_REG_WR = 4'h9;
    localparam logic [OP_W-1:0] OP_REG_SEL = 4'hD;

    localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

    typedef enum logic [3:0] {
        B_IDLE,
        B_WR_START,
        B_WR_DATA,
        B_WR_CRC,
        B_WR_MATCH,
        B_RD_STATUS,
        B_RD_DATA,
        B_RD_CRC,
        B_RD_TAIL
    } burst_st_e;

endpackage

// File: rtl/dbgcpu_crc_step.sv
module dbgcpu_crc_step #(
    parameter int          CRC_W = 32,
    parameter logic [CRC_W-1:0] POLY = dbgcpu_pkg::CRC_POLY
) (
    input  logic [CRC_W-1:0] crc_i,
    input  logic             bit_i,
    output logic [CRC_W-1:0] crc_o
);
    // Reflected serial update: one input bit per call.
    always_comb begin
        crc_o = crc_i >> 1;
        if (bit_i ^ crc_i[0]) begin
            crc_o = crc_o ^ POLY;
        end
    end
endmodule

// File: rtl/dbgcpu_cmd_dec.sv
module dbgcpu_cmd_dec
    import dbgcpu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic              shift_i,
    input  logic              update_i,
    input  logic              tdi_i,
    input  logic              busy_i,
    output logic              nop_p_o,
    output logic              sel_p_o,
    output logic              wr_p_o,
    output logic              bwr_p_o,
    output logic              brd_p_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [CTRL_W-1:0] wdata_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CNT_W-1:0]  cnt_o
);
    localparam int BURST_W = 1 + OP_W + ADDR_W + CNT_W;
    localparam int REG_W   = 1 + OP_W + IDX_W + CTRL_W;
    localparam int CMD_W   = (BURST_W > REG_W) ? BURST_W : REG_W;
    localparam int OP_TOP  = CMD_W - 2;
    localparam int IDX_TOP = CMD_W - 2 - OP_W;
    localparam int DAT_TOP = IDX_TOP - IDX_W;

    logic [CMD_W-1:0] sr_q;
    logic [OP_W-1:0]  op;
    logic             act;

    // Newest bit enters at the top, so the flag always sits in the MSB.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (!busy_i) begin
            if (capture_i) begin
                sr_q <= '0;
            end else if (shift_i) begin
                sr_q <= {tdi_i, sr_q[CMD_W-1:1]};
            end
        end
    end

    assign op      = sr_q[OP_TOP -: OP_W];
    assign act     = update_i && !busy_i && !sr_q[CMD_W-1];
    assign idx_o   = sr_q[IDX_TOP -: IDX_W];
    assign wdata_o = sr_q[DAT_TOP -: CTRL_W];
    assign addr_o  = sr_q[CNT_W +: ADDR_W];
    assign cnt_o   = sr_q[0 +: CNT_W];

    always_comb begin
        nop_p_o = 1'b0;
        sel_p_o = 1'b0;
        wr_p_o  = 1'b0;
        bwr_p_o = 1'b0;
        brd_p_o = 1'b0;
        if (act) begin
            unique case (op)
                OP_NOP:     nop_p_o = 1'b1;
                OP_REG_SEL: sel_p_o = 1'b1;
                OP_REG_WR:  wr_p_o  = 1'b1;
                OP_BWR32:   bwr_p_o = 1'b1;
                OP_BRD32:   brd_p_o = 1'b1;
                default:    ;
            endcase
        end
    end

    // R12: at most one command action per update
    p_one_action_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({nop_p_o, sel_p_o, wr_p_o, bwr_p_o, brd_p_o}) <= 1);

    // R11: nothing is decoded while a burst owns the scan path
    p_no_decode_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> !(bwr_p_o || brd_p_o || wr_p_o || sel_p_o || nop_p_o));
endmodule

// File: rtl/dbgcpu_ctrl_reg.sv
module dbgcpu_ctrl_reg
    import dbgcpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic              shift_i,
    input  logic              nop_p_i,
    input  logic              sel_p_i,
    input  logic              wr_p_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [CTRL_W-1:0] wdata_i,
    input  logic              bkpt_i,
    output logic              stall_o,
    output logic              reset_o,
    output logic              tdo_o
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [IDX_W-1:0]  sel_q;
    logic              armed_q;
    logic [CTRL_W-1:0] out_q;
    logic [CTRL_W-1:0] view;

    assign view = (sel_q == '0) ? ctrl_q : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            sel_q   <= '0;
            armed_q <= 1'b0;
            out_q   <= '0;
        end else begin
            if (wr_p_i && idx_i == '0) begin
                ctrl_q <= wdata_i;
            end
            if (bkpt_i) begin
                ctrl_q[0] <= 1'b1;
            end
            if (sel_p_i) begin
                sel_q <= idx_i;
            end
            if (capture_i) begin
                out_q   <= armed_q ? view : '0;
                armed_q <= 1'b0;
            end else if (shift_i) begin
                out_q <= out_q >> 1;
            end
            if (nop_p_i) begin
                armed_q <= 1'b1;
            end
        end
    end

    assign stall_o = ctrl_q[0];
    assign reset_o = ctrl_q[1];
    assign tdo_o   = out_q[0];

    p_bkpt_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bkpt_i |=> stall_o);

    p_reset_by_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reset_o) |-> $past(wr_p_i));

    p_sel_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sel_p_i) |-> $stable(sel_q));
endmodule

// File: rtl/dbgcpu_burst.sv
module dbgcpu_burst
    import dbgcpu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              update_i,
    input  logic              tdi_i,
    input  logic              start_wr_i,
    input  logic              start_rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [DATA_W-1:0] cpu_rdata_i,
    input  logic              cpu_ack_i,
    output logic              busy_o,
    output logic              tdo_o,
    output logic              cpu_req_o,
    output logic              cpu_we_o,
    output logic [ADDR_W-1:0] cpu_addr_o,
    output logic [DATA_W-1:0] cpu_wdata_o
);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(DATA_W - 1);
    localparam logic [ADDR_W-1:0] STRIDE   = ADDR_W'(DATA_W / 8);
    localparam logic [CNT_W-1:0]  ONE      = CNT_W'(1);

    burst_st_e state_q, state_nx;

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  xfer_left_q;
    logic [CNT_W-1:0]  fetch_left_q;
    logic [BIT_W-1:0]  bitcnt_q;
    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] buf_q;
    logic              buf_vld_q;
    logic [DATA_W-1:0] wbuf_q;
    logic              rd_pend_q;
    logic              wr_pend_q;
    logic [31:0]       crc_q;
    logic [31:0]       crc_nx;
    logic              crc_bit;
    logic              match_q;
    logic              last_bit;
    logic              rd_ready;
    logic              in_read;
    logic [DATA_W-1:0] sh_in;

    assign last_bit = (bitcnt_q == LAST_BIT);
    assign rd_ready = buf_vld_q || (xfer_left_q == '0);
    assign in_read  = (state_q == B_RD_STATUS) || (state_q == B_RD_DATA);
    assign sh_in    = {tdi_i, sh_q[DATA_W-1:1]};
    assign crc_bit  = (state_q == B_RD_DATA) ? sh_q[0] : tdi_i;

    dbgcpu_crc_step #(.CRC_W(32), .POLY(CRC_POLY)) u_crc (
        .crc_i (crc_q),
        .bit_i (crc_bit),
        .crc_o (crc_nx)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= B_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state_q;
        if (state_q != B_IDLE && update_i) begin
            state_nx = B_IDLE;
        end else begin
            unique case (state_q)
                B_IDLE: begin
                    if (start_wr_i)      state_nx = B_WR_START;
                    else if (start_rd_i) state_nx = B_RD_STATUS;
                end
                B_WR_START: begin
                    if (shift_i && tdi_i)
                        state_nx = (xfer_left_q == '0) ? B_WR_CRC : B_WR_DATA;
                end
                B_WR_DATA: begin
                    if (shift_i && last_bit)
                        state_nx = (xfer_left_q == ONE) ? B_WR_CRC : B_WR_DATA;
                end
                B_WR_CRC: begin
                    if (shift_i && last_bit) state_nx = B_WR_MATCH;
                end
                B_WR_MATCH: state_nx = B_WR_MATCH;
                B_RD_STATUS: begin
                    if (shift_i && rd_ready)
                        state_nx = (xfer_left_q == '0) ? B_RD_CRC : B_RD_DATA;
                end
                B_RD_DATA: begin
                    if (shift_i && last_bit)
                        state_nx = (xfer_left_q == ONE) ? B_RD_CRC : B_RD_DATA;
                end
                B_RD_CRC: begin
                    if (shift_i && last_bit) state_nx = B_RD_TAIL;
                end
                B_RD_TAIL: state_nx = B_RD_TAIL;
                default:   state_nx = B_IDLE;
            endcase
        end
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q       <= '0;
            xfer_left_q  <= '0;
            fetch_left_q <= '0;
            bitcnt_q     <= '0;
            sh_q         <= '0;
            buf_q        <= '0;
            buf_vld_q    <= 1'b0;
            wbuf_q       <= '0;
            rd_pend_q    <= 1'b0;
            wr_pend_q    <= 1'b0;
            crc_q        <= CRC_INIT;
            match_q      <= 1'b0;
        end else begin
            if (cpu_ack_i && (rd_pend_q || wr_pend_q)) begin
                if (rd_pend_q) begin
                    buf_q     <= cpu_rdata_i;
                    buf_vld_q <= 1'b1;
                end
                rd_pend_q <= 1'b0;
                wr_pend_q <= 1'b0;
                addr_q    <= addr_q + STRIDE;
            end
            if (in_read && !update_i && fetch_left_q != '0 && !buf_vld_q
                    && !rd_pend_q && !wr_pend_q) begin
                rd_pend_q    <= 1'b1;
                fetch_left_q <= fetch_left_q - ONE;
            end
            if (state_q != B_IDLE && update_i) begin
                fetch_left_q <= '0;
            end else begin
                unique case (state_q)
                    B_IDLE: begin
                        if (start_wr_i || start_rd_i) begin
                            addr_q       <= addr_i;
                            xfer_left_q  <= cnt_i;
                            fetch_left_q <= start_rd_i ? cnt_i : '0;
                            crc_q        <= CRC_INIT;
                            bitcnt_q     <= '0;
                            buf_vld_q    <= 1'b0;
                            match_q      <= 1'b0;
                        end
                    end
                    B_WR_START: begin
                        if (shift_i && tdi_i) bitcnt_q <= '0;
                    end
                    B_WR_DATA: begin
                        if (shift_i) begin
                            sh_q     <= sh_in;
                            crc_q    <= crc_nx;
                            bitcnt_q <= last_bit ? '0 : bitcnt_q + 1'b1;
                            if (last_bit) begin
                                wbuf_q      <= sh_in;
                                wr_pend_q   <= 1'b1;
                                xfer_left_q <= xfer_left_q - ONE;
                            end
                        end
                    end
                    B_WR_CRC: begin
                        if (shift_i) begin
                            sh_q     <= sh_in;
                            bitcnt_q <= last_bit ? '0 : bitcnt_q + 1'b1;
                            if (last_bit) match_q <= (sh_in[31:0] == crc_q);
                        end
                    end
                    B_RD_STATUS: begin
                        if (shift_i && rd_ready) begin
                            bitcnt_q <= '0;
                            if (xfer_left_q != '0) begin
                                sh_q      <= buf_q;
                                buf_vld_q <= 1'b0;
                            end else begin
                                sh_q <= DATA_W'(crc_q);
                            end
                        end
                    end
                    B_RD_DATA: begin
                        if (shift_i) begin
                            sh_q     <= sh_q >> 1;
                            crc_q    <= crc_nx;
                            bitcnt_q <= last_bit ? '0 : bitcnt_q + 1'b1;
                            if (last_bit) begin
                                xfer_left_q <= xfer_left_q - ONE;
                                if (xfer_left_q == ONE) begin
                                    sh_q <= DATA_W'(crc_nx);
                                end else begin
                                    sh_q      <= buf_q;
                                    buf_vld_q <= 1'b0;
                                end
                            end
                        end
                    end
                    B_RD_CRC: begin
                        if (shift_i) begin
                            sh_q     <= sh_q >> 1;
                            bitcnt_q <= last_bit ? '0 : bitcnt_q + 1'b1;
                        end
                    end
                    B_WR_MATCH, B_RD_TAIL: ;
                    default: ;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        tdo_o = 1'b0;
        unique case (state_q)
            B_RD_STATUS:         tdo_o = rd_ready;
            B_RD_DATA, B_RD_CRC: tdo_o = sh_q[0];
            B_WR_MATCH:          tdo_o = match_q;
            default:             tdo_o = 1'b0;
        endcase
    end

    assign busy_o      = (state_q != B_IDLE);
    assign cpu_req_o   = rd_pend_q || wr_pend_q;
    assign cpu_we_o    = wr_pend_q;
    assign cpu_addr_o  = addr_q;
    assign cpu_wdata_o = wbuf_q;

    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_o && !cpu_ack_i |=> cpu_req_o && $stable(cpu_addr_o)
            && $stable(cpu_we_o) && $stable(cpu_wdata_o));

    p_one_pending_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_pend_q && wr_pend_q));

    p_update_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && update_i |=> !busy_o);

    p_write_from_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_pend_q) |-> $past(state_q) == B_WR_DATA);

    p_fetch_in_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_pend_q) |-> $past(in_read));
endmodule

// File: rtl/dbgcpu_port.sv
module dbgcpu_port
    import dbgcpu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_sel_i,
    input  logic              scan_capture_i,
    input  logic              scan_shift_i,
    input  logic              scan_update_i,
    input  logic              scan_tdi_i,
    output logic              scan_tdo_o,
    input  logic              cpu_bkpt_i,
    output logic              cpu_stall_o,
    output logic              cpu_reset_o,
    output logic              cpu_req_o,
    output logic              cpu_we_o,
    output logic [ADDR_W-1:0] cpu_addr_o,
    output logic [DATA_W-1:0] cpu_wdata_o,
    input  logic [DATA_W-1:0] cpu_rdata_i,
    input  logic              cpu_ack_i
);
    logic cap_g, sh_g, up_g;
    logic busy;
    logic nop_p, sel_p, wr_p, bwr_p, brd_p;
    logic [IDX_W-1:0]  idx;
    logic [CTRL_W-1:0] wdata;
    logic [ADDR_W-1:0] cmd_addr;
    logic [CNT_W-1:0]  cmd_cnt;
    logic tdo_ctrl, tdo_burst;

    assign cap_g = scan_sel_i && scan_capture_i;
    assign sh_g  = scan_sel_i && scan_shift_i;
    assign up_g  = scan_sel_i && scan_update_i;

    dbgcpu_cmd_dec #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (cap_g),
        .shift_i   (sh_g),
        .update_i  (up_g),
        .tdi_i     (scan_tdi_i),
        .busy_i    (busy),
        .nop_p_o   (nop_p),
        .sel_p_o   (sel_p),
        .wr_p_o    (wr_p),
        .bwr_p_o   (bwr_p),
        .brd_p_o   (brd_p),
        .idx_o     (idx),
        .wdata_o   (wdata),
        .addr_o    (cmd_addr),
        .cnt_o     (cmd_cnt)
    );

    dbgcpu_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (cap_g && !busy),
        .shift_i   (sh_g && !busy),
        .nop_p_i   (nop_p),
        .sel_p_i   (sel_p),
        .wr_p_i    (wr_p),
        .idx_i     (idx),
        .wdata_i   (wdata),
        .bkpt_i    (cpu_bkpt_i),
        .stall_o   (cpu_stall_o),
        .reset_o   (cpu_reset_o),
        .tdo_o     (tdo_ctrl)
    );

    dbgcpu_burst #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_burst (
        .clk         (clk),
        .rst_n       (rst_n),
        .shift_i     (sh_g),
        .update_i    (up_g),
        .tdi_i       (scan_tdi_i),
        .start_wr_i  (bwr_p),
        .start_rd_i  (brd_p),
        .addr_i      (cmd_addr),
        .cnt_i       (cmd_cnt),
        .cpu_rdata_i (cpu_rdata_i),
        .cpu_ack_i   (cpu_ack_i),
        .busy_o      (busy),
        .tdo_o       (tdo_burst),
        .cpu_req_o   (cpu_req_o),
        .cpu_we_o    (cpu_we_o),
        .cpu_addr_o  (cpu_addr_o),
        .cpu_wdata_o (cpu_wdata_o)
    );

    assign scan_tdo_o = busy ? tdo_burst : tdo_ctrl;

    p_unsel_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_sel_i && !cpu_bkpt_i |=> $stable(cpu_stall_o) && $stable(cpu_reset_o));
endmodule

// File: tb/dbgcpu_port_tb.sv
module dbgcpu_port_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b1, capture = 1'b0, shift = 1'b0, update = 1'b0, tdi = 1'b0;
    logic        tdo;
    logic        bkpt = 1'b0;
    logic        stall, rst_cpu, req, we, ack;
    logic [31:0] addr, wdata, rdata;

    int nchk = 0;
    int nerr = 0;

    bit          tx_q[$];
    bit          rx_q[$];
    logic [31:0] wq_addr[$];
    logic [31:0] wq_data[$];
    logic [31:0] smem [16];
    logic [31:0] mdl  [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    dbgcpu_port u_dut (
        .clk(clk), .rst_n(rst_n),
        .scan_sel_i(sel), .scan_capture_i(capture), .scan_shift_i(shift),
        .scan_update_i(update), .scan_tdi_i(tdi), .scan_tdo_o(tdo),
        .cpu_bkpt_i(bkpt), .cpu_stall_o(stall), .cpu_reset_o(rst_cpu),
        .cpu_req_o(req), .cpu_we_o(we), .cpu_addr_o(addr), .cpu_wdata_o(wdata),
        .cpu_rdata_i(rdata), .cpu_ack_i(ack)
    );

    function automatic logic [31:0] pre(int i);
        return 32'h1357_0000 + i * 32'h0102_0304;
    endfunction

    // Processor debug register stub: acknowledges one cycle after a request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack   <= 1'b0;
            rdata <= '0;
            for (int i = 0; i < 16; i++) smem[i] <= pre(i);
        end else begin
            ack <= req && !ack;
            if (req && !ack) begin
                if (we) smem[addr[5:2]] <= wdata;
                rdata <= smem[addr[5:2]];
            end
        end
    end

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: every acknowledged write must match the next expected item.
    always @(negedge clk) begin
        if (rst_n && req && ack && we) begin
            if (wq_addr.size() == 0) begin
                check("R7 unexpected cpu write", {addr, wdata}, 64'h0);
            end else begin
                check("R7 write address", addr, wq_addr.pop_front());
                check("R7 write data", wdata, wq_data.pop_front());
            end
        end
    end

    function automatic logic [31:0] crc_upd(logic [31:0] c, bit b);
        logic [31:0] n = c >> 1;
        if (b ^ c[0]) n = n ^ 32'hEDB8_8320;
        return n;
    endfunction

    task automatic push(logic [63:0] v, int n);
        for (int i = 0; i < n; i++) tx_q.push_back(v[i]);
    endtask

    task automatic scan(bit do_upd);
        rx_q.delete();
        capture = 1'b1;
        @(negedge clk);
        capture = 1'b0;
        while (tx_q.size() > 0) begin
            shift = 1'b1;
            tdi = tx_q.pop_front();
            #1;
            rx_q.push_back(tdo);
            @(negedge clk);
        end
        shift = 1'b0;
        tdi = 1'b0;
        if (do_upd) begin
            update = 1'b1;
            @(negedge clk);
            update = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic reg_cmd(logic [3:0] op, logic idx, logic [1:0] d, bit flag);
        if (op == 4'h9) push(d, 2);
        if (op == 4'h9 || op == 4'hD) push(idx, 1);
        push(op, 4);
        push(flag, 1);
        scan(1);
    endtask

    task automatic read_reg(output logic [1:0] v);
        reg_cmd(4'h0, 0, 0, 0);
        reg_cmd(4'h0, 0, 0, 0);
        v = {rx_q[1], rx_q[0]};
    endtask

    task automatic burst_cmd(logic [3:0] op, logic [31:0] a, logic [15:0] n);
        push(n, 16);
        push(a, 32);
        push(op, 4);
        push(0, 1);
        scan(1);
    endtask

    task automatic burst_write(logic [31:0] a, int n, logic [31:0] seed, bit bad);
        logic [31:0] c = 32'hFFFF_FFFF;
        burst_cmd(4'h3, a, 16'(n));
        push(0, 3);
        push(1, 1);
        for (int k = 0; k < n; k++) begin
            logic [31:0] w = seed ^ (32'h0F1E_2D3C * (k + 1));
            push(w, 32);
            for (int i = 0; i < 32; i++) c = crc_upd(c, w[i]);
            wq_addr.push_back(a + 32'(4 * k));
            wq_data.push_back(w);
            mdl[(a[5:2] + k) % 16] = w;
        end
        push(bad ? ~c : c, 32);
        push(0, 1);
        scan(1);
        check(bad ? "R8 mismatch bit" : "R8 match bit", rx_q[rx_q.size()-1], bad ? 0 : 1);
        check("R7 all words written", wq_addr.size(), 0);
    endtask

    task automatic burst_read(logic [31:0] a, int n);
        int p = -1;
        logic [31:0] c = 32'hFFFF_FFFF;
        logic [31:0] exp_q[$];
        burst_cmd(4'h7, a, 16'(n));
        for (int k = 0; k < n; k++) exp_q.push_back(mdl[(a[5:2] + k) % 16]);
        push(0, 8 + 32 * n + 32 + 4);
        scan(1);
        for (int i = 7; i >= 0; i--) if (rx_q[i]) p = i;
        check("R9 ready bit within 8 shifts", p >= 0, 1);
        if (p < 0) return;
        p++;
        for (int k = 0; k < n; k++) begin
            logic [31:0] w;
            for (int i = 0; i < 32; i++) w[i] = rx_q[p + 32 * k + i];
            for (int i = 0; i < 32; i++) c = crc_upd(c, w[i]);
            check("R9 read word", w, exp_q.pop_front());
        end
        begin
            logic [31:0] g;
            for (int i = 0; i < 32; i++) g[i] = rx_q[p + 32 * n + i];
            check("R10 read checksum", g, c);
            check("R10 tail zero", rx_q[p + 32 * n + 32], 0);
        end
    endtask

    initial begin
        repeat (CLK_PERIOD * 10000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [1:0] v;
        for (int i = 0; i < 16; i++) mdl[i] = pre(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        check("R2 stall after reset", stall, 0);
        check("R2 cpu reset after reset", rst_cpu, 0);
        check("R2 tdo after reset", tdo, 0);
        check("R2 no request after reset", req, 0);
        read_reg(v);
        check("R2 register after reset", v, 2'b00);

        // R3 / R4: writes and read-by-NOP
        reg_cmd(4'h9, 0, 2'b01, 0);
        check("R3 stall bit", {rst_cpu, stall}, 2'b01);
        read_reg(v);
        check("R4 readback 01", v, 2'b01);
        reg_cmd(4'h9, 0, 2'b10, 0);
        check("R3 reset bit", {rst_cpu, stall}, 2'b10);
        reg_cmd(4'h9, 0, 2'b10, 0);
        reg_cmd(4'hD, 0, 0, 0);
        check("R4 no NOP gives zeros", {rx_q[1], rx_q[0]}, 2'b00);
        read_reg(v);
        check("R4 readback 10", v, 2'b10);

        // R5: selection held, index 1 reads zero, writes to it ignored
        reg_cmd(4'hD, 1, 0, 0);
        read_reg(v);
        check("R5 index 1 reads zero", v, 2'b00);
        read_reg(v);
        check("R5 selection held", v, 2'b00);
        reg_cmd(4'h9, 1, 2'b01, 0);
        check("R5 write index 1 ignored", {rst_cpu, stall}, 2'b10);
        reg_cmd(4'hD, 0, 0, 0);
        read_reg(v);
        check("R5 index 0 again", v, 2'b10);

        // R6: breakpoint stall
        reg_cmd(4'h9, 0, 2'b00, 0);
        bkpt = 1'b1;
        @(negedge clk);
        bkpt = 1'b0;
        check("R6 breakpoint stalls", stall, 1);
        read_reg(v);
        check("R6 stall reads back", v, 2'b01);
        reg_cmd(4'h9, 0, 2'b00, 0);
        check("R6 write clears stall", stall, 0);

        // R12 / R1: ignored commands
        sel = 1'b0;
        reg_cmd(4'h9, 0, 2'b11, 0);
        sel = 1'b1;
        check("R12 unselected scan ignored", {rst_cpu, stall}, 2'b00);
        reg_cmd(4'h9, 0, 2'b11, 1);
        check("R1 flag set ignored", {rst_cpu, stall}, 2'b00);
        burst_cmd(4'h5, 32'h0, 16'd1);
        check("R12 undefined opcode no request", req, 0);
        reg_cmd(4'h9, 0, 2'b01, 0);
        check("R12 still decoding", {rst_cpu, stall}, 2'b01);
        reg_cmd(4'h9, 0, 2'b00, 0);

        // R7 / R8 / R9 / R10: bursts
        burst_write(32'h10, 3, 32'hA5A5_0000, 0);
        burst_read(32'h10, 3);
        burst_write(32'h30, 1, 32'h00C0_FFEE, 1);
        burst_read(32'h00, 4);
        burst_read(32'h2C, 2);

        // R11: abort a read burst with an update
        burst_cmd(4'h7, 32'h0, 16'd4);
        push(32'h0009_0009, 20);
        scan(1);
        repeat (4) @(negedge clk);
        reg_cmd(4'h9, 0, 2'b01, 0);
        check("R11 decode after abort", stall, 1);
        read_reg(v);
        check("R11 readback after abort", v, 2'b01);
        check("R13 bus idle at end", req, 0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule